// File: doc/BRIEF.md
# Multidrop Address Wake-Up Framer

This block adds address/data tagging to the character framing of an asynchronous serial port, for a bus where many stations share a single line. On the transmit side it turns a data word into an ordered frame: a start bit, then the data bits LSB first, then one extra bit, then the stop bits. A bit-time tick from outside moves the frame onto the line one bit per tick. In multidrop mode the extra bit is the address/data tag. In parity mode it is the parity bit. In no-parity mode the frame has no extra bit.

On the receive side it takes a character that the bit sampler has already assembled. The character arrives with its extra bit and its error flags. The block decides whether the character goes into the receive FIFO and builds the FIFO entry. In multidrop mode a station whose receiver is switched off still watches the line. It passes address characters (tag 1) up so that software can wake and compare the address. It drops data characters (tag 0). Once software enables the receiver, every character is passed. The tag is stored in the status slot that parity mode uses for its parity error flag.

The mode field `mode_i` has this layout. Bits [4:3] select the format: 2'b00 is parity, 2'b01 and 2'b10 are no parity, 2'b11 is multidrop. Bit 2 is the parity sense in parity mode (0 even, 1 odd) and the transmitted tag in multidrop mode. Bits [1:0] give the data length, 5 plus the field value. Bit 5 selects two stop bits instead of one.

The FIFO status field `fifo_stat_o` has this layout: bit 0 overrun, bit 1 parity error or tag, bit 2 framing error, bit 3 break.

Top module: `mdrop_frame`

## Requirements
- R1: Multidrop behaviour applies only when `mode_i[4:3]` is 2'b11. With 2'b00 the extra bit is parity, and with 2'b01 or 2'b10 there is no extra bit.
- R2: After an accepted load, the line carries the frame LSB first, one bit per cycle with `tx_step_i` high. The order is a start bit 0, the programmed data bits LSB first, the tag (`mode_i[2]`) in multidrop mode, then one or two stop bits of 1. After the last stop bit `tx_busy_o` falls and the line idles at 1.
- R3: The tag and every other framing choice are taken from `mode_i` in the cycle the character is loaded. Later changes to `mode_i` do not alter a frame that is already on the line.
- R4: In multidrop mode with the receiver disabled, a character with tag 1 gives a `fifo_wr_o` pulse. A character with tag 0 and no break gives none.
- R5: In any mode with the receiver enabled, every character gives a `fifo_wr_o` pulse, whatever its extra bit.
- R6: In multidrop mode the received tag is written to `fifo_stat_o[1]`. No parity check takes place in multidrop mode.
- R7: Framing error, break and overrun flags are copied into `fifo_stat_o[2]`, `[3]` and `[0]` for every written character. This holds whether the receiver is enabled or not. A break character is written even by a disabled multidrop receiver.
- R8: In parity mode the transmitted extra bit makes the count of ones over the data bits and that bit even (`mode_i[2]`=0) or odd (`mode_i[2]`=1). A received character whose data bits and extra bit break that rule sets `fifo_stat_o[1]`.
- R9: Outside multidrop mode a disabled receiver writes nothing. In no-parity mode `fifo_stat_o[1]` is 0 and the transmitted frame has no extra bit.
- R10: `fifo_wr_o` is a one-cycle pulse in the cycle after `rx_valid_i`. `fifo_data_o` holds the received data with bits above the programmed length forced to 0.
- R11: A load request while a frame is still on the line is ignored. The frame in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 6 | Framing mode field (layout above) |
| rx_en_i | input | 1 | Receiver enable state |
| rx_valid_i | input | 1 | Assembled character present this cycle |
| rx_data_i | input | DATA_W | Received data bits, LSB first |
| rx_extra_i | input | 1 | Received bit after the data (tag or parity) |
| rx_frame_err_i | input | 1 | Missing stop bit on this character |
| rx_break_i | input | 1 | Break seen on this character |
| rx_overrun_i | input | 1 | Overrun flagged with this character |
| fifo_wr_o | output | 1 | Receive FIFO write strobe |
| fifo_data_o | output | DATA_W | Data for the FIFO entry |
| fifo_stat_o | output | 4 | Status for the FIFO entry |
| tx_load_i | input | 1 | Request to load a character |
| tx_data_i | input | DATA_W | Character to transmit |
| tx_step_i | input | 1 | Bit-time tick: advance the line by one bit |
| tx_line_o | output | 1 | Serial transmit line |
| tx_busy_o | output | 1 | A frame is on the line |

## Verification
The bench targets these corner cases:
- A data-tagged character reaching a disabled multidrop receiver. A filter that ignored the enable state would write it.
- A break character with tag 0 in the same situation. A filter that looked only at the tag would silently lose the break.
- A mode change, and a second load request, made halfway through a transmitted frame. A design that read `mode_i` live, or that accepted the reload, would emit a corrupted bit sequence.
- Five-bit and eight-bit lengths, one and two stop bits, and both parity senses. These expose an extra bit placed at the wrong index or data bits leaking past the programmed length.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

  localparam int STAT_W   = 4;
  localparam int STAT_OVR = 0;
  localparam int STAT_PT  = 1;
  localparam int STAT_FE  = 2;
  localparam int STAT_BRK = 3;

  typedef enum logic [1:0] {
    FMT_PARITY = 2'b00,
    FMT_NONE_A = 2'b01,
    FMT_NONE_B = 2'b10,
    FMT_MDROP  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pt;
    logic ovr;
  } rx_stat_t;

  // True when the format carries a bit between data and stop bits.
  function automatic logic fmt_has_extra(fmt_e fmt);
    return (fmt == FMT_PARITY) || (fmt == FMT_MDROP);
  endfunction

  // Value of that bit on transmit: tag in multidrop, parity otherwise.
  function automatic logic fmt_extra_bit(fmt_e fmt, logic sense, logic data_xor);
    return (fmt == FMT_MDROP) ? sense : (data_xor ^ sense);
  endfunction

  // Receive wake-up decision.
  function automatic logic rx_take(fmt_e fmt, logic en, logic tag, logic brk);
    if (en) return 1'b1;
    if (fmt == FMT_MDROP) return tag | brk;
    return 1'b0;
  endfunction

endpackage

// File: rtl/mdrop_tx_frame.sv
module mdrop_tx_frame
  import mdrop_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt_i,
  input  logic              sense_i,
  input  logic              stop2_i,
  input  logic [LEN_W-1:0]  nbits_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              step_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              load_fire_o
);

  logic [FRAME_W-1:0] shreg_q;
  logic [LEN_W-1:0]   left_q;
  logic [FRAME_W-1:0] frame_d;
  logic [LEN_W-1:0]   len_d;
  logic               extra_en;
  logic               extra_bit;

  function automatic logic [DATA_W-1:0] keep_low(logic [DATA_W-1:0] d,
                                                 logic [LEN_W-1:0] nb);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++)
      r[i] = (i < int'(nb)) ? d[i] : 1'b0;
    return r;
  endfunction

  // Frame image, LSB goes out first; positions past the frame stay at idle 1.
  function automatic logic [FRAME_W-1:0] build(logic [DATA_W-1:0] d,
                                               logic [LEN_W-1:0] nb,
                                               logic xen, logic xbit);
    logic [FRAME_W-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(nb)) f[1+i] = d[i];
    if (xen) f[1+int'(nb)] = xbit;
    return f;
  endfunction

  always_comb begin
    extra_en  = fmt_has_extra(fmt_i);
    extra_bit = fmt_extra_bit(fmt_i, sense_i, ^keep_low(data_i, nbits_i));
    frame_d   = build(data_i, nbits_i, extra_en, extra_bit);
    len_d     = nbits_i + LEN_W'(2) + LEN_W'(extra_en) + LEN_W'(stop2_i);
  end

  assign load_fire_o = load_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      left_q  <= '0;
      busy_o  <= 1'b0;
    end else if (load_fire_o) begin
      shreg_q <= frame_d;
      left_q  <= len_d;
      busy_o  <= 1'b1;
    end else if (busy_o && step_i) begin
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      left_q  <= left_q - LEN_W'(1);
      busy_o  <= (left_q != LEN_W'(1));
    end
  end

  assign line_o = busy_o ? shreg_q[0] : 1'b1;

endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W + 5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt_i,
  input  logic              sense_i,
  input  logic [LEN_W-1:0]  nbits_i,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              extra_i,
  input  logic              fe_i,
  input  logic              brk_i,
  input  logic              ovr_i,
  output logic              accept_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] data_o,
  output rx_stat_t          stat_o
);

  logic [DATA_W-1:0] masked;
  rx_stat_t          stat_d;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      masked[i] = (i < int'(nbits_i)) && data_i[i];
    stat_d.ovr = ovr_i;
    stat_d.fe  = fe_i;
    stat_d.brk = brk_i;
    unique case (fmt_i)
      FMT_MDROP:  stat_d.pt = extra_i;
      FMT_PARITY: stat_d.pt = (^masked) != (extra_i ^ sense_i);
      default:    stat_d.pt = 1'b0;
    endcase
  end

  assign accept_o = valid_i && rx_take(fmt_i, en_i, extra_i, brk_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_o   <= 1'b0;
      data_o <= '0;
      stat_o <= '0;
    end else begin
      wr_o <= accept_o;
      if (accept_o) begin
        data_o <= masked;
        stat_o <= stat_d;
      end
    end
  end

endmodule

// File: rtl/mdrop_frame.sv
module mdrop_frame
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        mode_i,
  input  logic              rx_en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_extra_i,
  input  logic              rx_frame_err_i,
  input  logic              rx_break_i,
  input  logic              rx_overrun_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic [3:0]        fifo_stat_o,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_step_i,
  output logic              tx_line_o,
  output logic              tx_busy_o
);

  localparam int FRAME_W  = DATA_W + 4;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int MIN_BITS = DATA_W - 3;

  fmt_e             fmt;
  logic             sense;
  logic             stop2;
  logic [LEN_W-1:0] nbits;
  logic             md_active;
  logic             rx_accept;
  logic             tx_load_fire;
  rx_stat_t         stat_q;

  assign fmt       = fmt_e'(mode_i[4:3]);
  assign sense     = mode_i[2];
  assign stop2     = mode_i[5];
  assign nbits     = LEN_W'(MIN_BITS) + LEN_W'(mode_i[1:0]);
  assign md_active = (fmt == FMT_MDROP);

  mdrop_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_i       (fmt),
    .sense_i     (sense),
    .stop2_i     (stop2),
    .nbits_i     (nbits),
    .load_i      (tx_load_i),
    .data_i      (tx_data_i),
    .step_i      (tx_step_i),
    .line_o      (tx_line_o),
    .busy_o      (tx_busy_o),
    .load_fire_o (tx_load_fire)
  );

  mdrop_rx_filter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_i    (fmt),
    .sense_i  (sense),
    .nbits_i  (nbits),
    .en_i     (rx_en_i),
    .valid_i  (rx_valid_i),
    .data_i   (rx_data_i),
    .extra_i  (rx_extra_i),
    .fe_i     (rx_frame_err_i),
    .brk_i    (rx_break_i),
    .ovr_i    (rx_overrun_i),
    .accept_o (rx_accept),
    .wr_o     (fifo_wr_o),
    .data_o   (fifo_data_o),
    .stat_o   (stat_q)
  );

  assign fifo_stat_o = stat_q;

endmodule

// File: rtl/mdrop_frame_sva.sv
module mdrop_frame_sva #(
  parameter int DATA_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       md_active,
  input logic       rx_en_i,
  input logic       rx_valid_i,
  input logic       rx_extra_i,
  input logic       rx_break_i,
  input logic       rx_frame_err_i,
  input logic       rx_overrun_i,
  input logic       rx_accept,
  input logic       fifo_wr_o,
  input logic [3:0] fifo_stat_o,
  input logic       tx_load_fire,
  input logic       tx_step_i,
  input logic       tx_line_o,
  input logic       tx_busy_o
);

  p_wr_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o |-> $past(rx_valid_i));

  p_drop_data_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && md_active && !rx_en_i && !rx_extra_i && !rx_break_i) |=> !fifo_wr_o);

  p_wake_on_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && md_active && rx_extra_i) |=> fifo_wr_o);

  p_enabled_takes_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && rx_en_i) |=> fifo_wr_o);

  p_tag_in_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && md_active) |=> (fifo_stat_o[1] == $past(rx_extra_i)));

  p_flags_copied_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |=> (fifo_stat_o[3] == $past(rx_break_i)) &&
                  (fifo_stat_o[2] == $past(rx_frame_err_i)) &&
                  (fifo_stat_o[0] == $past(rx_overrun_i)));

  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_fire |=> (tx_busy_o && !tx_line_o));

  p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy_o && !tx_step_i) |=> ($stable(tx_line_o) && tx_busy_o));

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy_o |-> tx_line_o);

endmodule

bind mdrop_frame mdrop_frame_sva #(.DATA_W(DATA_W)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .md_active      (md_active),
  .rx_en_i        (rx_en_i),
  .rx_valid_i     (rx_valid_i),
  .rx_extra_i     (rx_extra_i),
  .rx_break_i     (rx_break_i),
  .rx_frame_err_i (rx_frame_err_i),
  .rx_overrun_i   (rx_overrun_i),
  .rx_accept      (rx_accept),
  .fifo_wr_o      (fifo_wr_o),
  .fifo_stat_o    (fifo_stat_o),
  .tx_load_fire   (tx_load_fire),
  .tx_step_i      (tx_step_i),
  .tx_line_o      (tx_line_o),
  .tx_busy_o      (tx_busy_o)
);

// File: tb/mdrop_frame_tb.sv
`timescale 1ns/1ps
module mdrop_frame_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    mode_i = '0;
  logic          rx_en_i = 1'b0, rx_valid_i = 1'b0, rx_extra_i = 1'b0;
  logic [DW-1:0] rx_data_i = '0;
  logic          rx_frame_err_i = 1'b0, rx_break_i = 1'b0, rx_overrun_i = 1'b0;
  logic          fifo_wr_o;
  logic [DW-1:0] fifo_data_o;
  logic [3:0]    fifo_stat_o;
  logic          tx_load_i = 1'b0, tx_step_i = 1'b0;
  logic [DW-1:0] tx_data_i = '0;
  logic          tx_line_o, tx_busy_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  mdrop_frame #(.DATA_W(DW)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nb_of(logic [5:0] m);
    return 5 + int'(m[1:0]);
  endfunction

  function automatic logic [DW-1:0] trim(logic [5:0] m, logic [DW-1:0] d);
    return d & ((DW'(1) << nb_of(m)) - DW'(1));
  endfunction

  function automatic logic ones_odd(logic [DW-1:0] d);
    int c = 0;
    for (int i = 0; i < DW; i++) c += int'(d[i]);
    return (c % 2) == 1;
  endfunction

  // Expected receive results
  function automatic logic exp_wr(logic [5:0] m, logic en, logic tag, logic brk);
    if (en) return 1'b1;
    return (m[4:3] == 2'b11) && (tag || brk);
  endfunction

  function automatic logic exp_pt(logic [5:0] m, logic [DW-1:0] d, logic x);
    if (m[4:3] == 2'b11) return x;
    if (m[4:3] == 2'b00) return (ones_odd(trim(m, d)) ^ x) != m[2];
    return 1'b0;
  endfunction

  task automatic rx_one(string req, logic [5:0] m, logic en, logic [DW-1:0] d,
                        logic x, logic fe, logic brk, logic ovr);
    logic w;
    @(negedge clk);
    mode_i = m; rx_en_i = en; rx_data_i = d; rx_extra_i = x;
    rx_frame_err_i = fe; rx_break_i = brk; rx_overrun_i = ovr; rx_valid_i = 1'b1;
    @(negedge clk);
    rx_valid_i = 1'b0;
    w = exp_wr(m, en, x, brk);
    check(req, 32'(fifo_wr_o), 32'(w));
    if (w) begin
      check({req, " data"}, 32'(fifo_data_o), 32'(trim(m, d)));
      check({req, " stat"}, 32'(fifo_stat_o),
            32'({brk, fe, exp_pt(m, d, x), ovr}));
    end
    @(negedge clk);
    check({req, " one-cycle R10"}, 32'(fifo_wr_o), 32'd0);
  endtask

  // Transmit a character; optionally disturb mode and request a reload mid-frame.
  task automatic tx_one(string req, logic [5:0] m, logic [DW-1:0] d, logic disturb);
    logic exp_bits [$];
    logic got_bits [$];
    logic xb;
    int   nb = nb_of(m);
    exp_bits.push_back(1'b0);
    for (int i = 0; i < nb; i++) exp_bits.push_back(d[i]);
    if (m[4:3] == 2'b11) exp_bits.push_back(m[2]);
    else if (m[4:3] == 2'b00) begin
      xb = ones_odd(trim(m, d)) ^ m[2];
      exp_bits.push_back(xb);
    end
    exp_bits.push_back(1'b1);
    if (m[5]) exp_bits.push_back(1'b1);
    @(negedge clk);
    mode_i = m; tx_data_i = d; tx_load_i = 1'b1;
    @(negedge clk);
    tx_load_i = 1'b0;
    for (int k = 0; k < exp_bits.size(); k++) begin
      got_bits.push_back(tx_line_o);
      tx_step_i = 1'b1;
      if (disturb && k == 2) mode_i = 6'($urandom);
      if (disturb && k == 3) begin tx_load_i = 1'b1; tx_data_i = ~d; end
      else tx_load_i = 1'b0;
      @(negedge clk);
    end
    tx_step_i = 1'b0; tx_load_i = 1'b0;
    for (int k = 0; k < exp_bits.size(); k++)
      if (got_bits[k] !== exp_bits[k]) begin
        check($sformatf("%s bit %0d", req, k), 32'(got_bits[k]), 32'(exp_bits[k]));
        break;
      end
    n_checks++;
    check({req, " idle R2"}, 32'({tx_busy_o, tx_line_o}), 32'b01);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset", 32'({fifo_wr_o, tx_busy_o, tx_line_o}), 32'b001);

    // R4: disabled multidrop, address vs data tag
    rx_one("R4 addr wakes", 6'b011011, 1'b0, 8'hA5, 1'b1, 0, 0, 0);
    rx_one("R4 data dropped", 6'b011011, 1'b0, 8'h5A, 1'b0, 0, 0, 0);
    // R5: enabled takes tag 0
    rx_one("R5 enabled data", 6'b011011, 1'b1, 8'h3C, 1'b0, 0, 0, 0);
    // R6: tag into status bit 1, no parity check
    rx_one("R6 tag stored", 6'b011111, 1'b1, 8'h01, 1'b1, 0, 0, 1);
    // R7: break while disabled multidrop with tag 0
    rx_one("R7 break kept", 6'b011000, 1'b0, 8'h00, 1'b0, 1, 1, 0);
    rx_one("R7 flags on addr", 6'b011001, 1'b0, 8'hFF, 1'b1, 1, 0, 1);
    // R1/R9: other formats with receiver disabled write nothing
    rx_one("R9 none disabled", 6'b001011, 1'b0, 8'h11, 1'b1, 0, 0, 0);
    rx_one("R1 parity disabled", 6'b000011, 1'b0, 8'h11, 1'b1, 0, 1, 0);
    // R8: parity errors even/odd
    rx_one("R8 even ok", 6'b000011, 1'b1, 8'h03, 1'b0, 0, 0, 0);
    rx_one("R8 even bad", 6'b000011, 1'b1, 8'h03, 1'b1, 0, 0, 0);
    rx_one("R8 odd ok", 6'b000111, 1'b1, 8'h03, 1'b1, 0, 0, 0);
    // R10: length trimming, 5 bits
    rx_one("R10 trim5", 6'b011000, 1'b1, 8'hFF, 1'b0, 0, 0, 0);

    // Transmit directed
    tx_one("R2 md addr 8b", 6'b011111, 8'hC3, 1'b0);
    tx_one("R2 md data 5b 2stop", 6'b111000, 8'hFF, 1'b0);
    tx_one("R8 odd parity", 6'b000111, 8'h07, 1'b0);
    tx_one("R9 no extra", 6'b010010, 8'h55, 1'b0);
    tx_one("R3 R11 disturbed", 6'b011110, 8'h9A, 1'b1);
    tx_one("R3 R11 disturbed 5b", 6'b111001, 8'h16, 1'b1);

    // Random mix
    for (int n = 0; n < 200; n++) begin
      logic [5:0] m = 6'($urandom);
      rx_one("R4 R5 R6 R7 R8 rand", m, 1'($urandom), 8'($urandom), 1'($urandom),
             1'($urandom), ($urandom % 8) == 0, 1'($urandom));
    end
    for (int n = 0; n < 60; n++)
      tx_one("R2 R8 rand", 6'($urandom), 8'($urandom), 1'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule